// File: doc/BRIEF.md
# Bipolar Return-to-Zero Avionics Word Transmitter

This block serialises 32-bit avionics data words onto a differential pair that has three states: high, low and null. A host loads words into a 32-entry queue through a 16-bit write port. Each word takes two writes, lower half first. When the enable input is high, the transmitter takes words from the queue one at a time. Each bit is sent as a data-level half period followed by a null half period, and consecutive words are separated by a fixed null gap.

Two configuration inputs choose the bit rate and the handling of the last bit. The rate select picks either the fast timing or the slow timing, both counted in master clocks. The parity controls either replace bit 32 with an odd or even parity bit or send the 32 loaded bits unchanged. A test input forces the pair to null. A ready flag reports that the queue is empty and the serialiser is idle. A synchronous reset abandons any word in flight and empties the queue. It leaves the configuration inputs alone, because they belong to the host.

Top module: `a429_word_tx`

## Requirements
- R1: With `cfg_slow`=0, every bit drives its level for 5 clocks and then null for 5 clocks. After the data half of bit 32, the pair stays null for exactly 40 clocks before the next word's first data clock.
- R2: With `cfg_slow`=1, the data half and the null half each last 40 clocks, and the null gap after a word's last data half lasts 320 clocks.
- R3: Bit 1 of a word is stored in `wr_data[0]` of the lower half and is sent first; bit 32 is sent last. A one drives `line_a`=1/`line_b`=0, a zero drives `line_a`=0/`line_b`=1, and null drives both low. Both lines are never high together.
- R4: With `cfg_par_en`=1, bit 32 (word bit 31) is replaced so that the 32 sent bits hold an odd count of ones when `cfg_par_even`=0, and an even count when `cfg_par_even`=1.
- R5: With `cfg_par_en`=0, all 32 loaded bits are sent unchanged.
- R6: While `test_null` is 1, both lines are 0, whatever else the block is doing.
- R7: If `tx_enable` is 1 and the queue holds a word at a clock edge while the block is idle, bit 1 is on the lines from the next clock. Queued words follow one another with only the gap between them. `tx_ready` is 1 exactly when the queue is empty and no word or gap is in progress.
- R8: The queue holds 32 words, and `fifo_full` is 1 while it does. A word whose upper half is written while the queue is full is discarded.
- R9: Writes alternate between lower and upper half, starting with the lower half. A word enters the queue only when its upper half is written, so a lone lower half is never sent.
- R10: If `tx_enable` falls during a word, that word and its gap complete, and no further word starts until `tx_enable` is high again.
- R11: `rst`=1 at a clock edge makes both lines null, empties the queue (`tx_ready`=1, `fifo_full`=0) and returns the half-word sequence to the lower half, all from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous master reset, active high |
| cfg_slow | input | 1 | Rate select: 0 fast, 1 slow |
| cfg_par_en | input | 1 | 1 replaces bit 32 with parity |
| cfg_par_even | input | 1 | Parity sense: 0 odd, 1 even |
| wr_en | input | 1 | Write strobe for one half-word |
| wr_data | input | 16 | Half-word data, lower half first |
| tx_enable | input | 1 | Allows words to be taken from the queue |
| test_null | input | 1 | Forces both lines to null |
| line_a | output | 1 | Positive side of the pair |
| line_b | output | 1 | Negative side of the pair |
| tx_ready | output | 1 | Queue empty and serialiser idle |
| fifo_full | output | 1 | Queue holds 32 words |

## Verification
The bench compares the line pair against an expected waveform on every clock of each word. A design that has the half periods or the gap off by one clock, or that sends the bits in the wrong order, fails on the first clock that differs. The queue is filled with 33 words and then drained. A design that lets the 33rd word in, or loses one of the first 32, sends the wrong number of words. Other directed cases target behaviour that a faulty design would get wrong in a visible way. A lone lower half must stay unsent. Dropping the enable in the middle of a word must not cut that word short or start the next one. A reset in the middle of a word must silence the lines in the next clock, and no stale word may be sent after the reset.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_MARK  = 2'd1,
    TX_SPACE = 2'd2,
    TX_GAP   = 2'd3
  } tx_state_e;

  // Parity bit for 31 payload bits: even sense copies the XOR, odd inverts it.
  function automatic logic parity_fill(input logic [30:0] payload, input logic even_sense);
    logic x;
    x = ^payload;
    return even_sense ? x : ~x;
  endfunction

  // Word as it goes on the line, with or without parity replacement of bit 32.
  function automatic logic [31:0] frame_word(input logic [31:0] raw,
                                             input logic par_en,
                                             input logic even_sense);
    logic [31:0] w;
    w = raw;
    if (par_en) w[31] = parity_fill(raw[30:0], even_sense);
    return w;
  endfunction

  // Picks the clock count of a phase from the rate select.
  function automatic int unsigned phase_len(input logic slow,
                                            input int unsigned fast_len,
                                            input int unsigned slow_len);
    return slow ? slow_len : fast_len;
  endfunction

endpackage

// File: rtl/a429_half_loader.sv
module a429_half_loader #(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [HALF_W-1:0]   wr_data,
  output logic                push,
  output logic [2*HALF_W-1:0] push_word
);
  logic              upper_next;
  logic [HALF_W-1:0] low_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_next <= 1'b0;
      low_hold   <= '0;
    end else if (wr_en) begin
      upper_next <= ~upper_next;
      if (!upper_next) low_hold <= wr_data;
    end
  end

  assign push      = wr_en && upper_next;
  assign push_word = {wr_data, low_hold};
endmodule

// File: rtl/a429_tx_fifo.sv
module a429_tx_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push,
  input  logic [WIDTH-1:0]         push_word,
  input  logic                     pop,
  output logic [WIDTH-1:0]         head_word,
  output logic                     empty,
  output logic                     full,
  output logic [$clog2(DEPTH):0]   fill
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_word;
  end

  assign head_word = mem[rd_ptr];
  assign fill      = count;
endmodule

// File: rtl/a429_tx_serializer.sv
module a429_tx_serializer
  import a429_tx_pkg::*;
#(
  parameter int WORD_BITS = 32,
  parameter int HALF_FAST = 5,
  parameter int HALF_SLOW = 40,
  parameter int GAP_FAST  = 40,
  parameter int GAP_SLOW  = 320
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_slow,
  input  logic                 cfg_par_en,
  input  logic                 cfg_par_even,
  input  logic                 tx_enable,
  input  logic                 test_null,
  input  logic                 have_word,
  input  logic [WORD_BITS-1:0] head_word,
  output logic                 pop,
  output logic                 word_done,
  output logic                 busy,
  output logic                 line_a,
  output logic                 line_b
);
  localparam int MAXLEN = (GAP_SLOW > HALF_SLOW) ? GAP_SLOW : HALF_SLOW;
  localparam int CNT_W  = $clog2(MAXLEN + 1);
  localparam int IDX_W  = $clog2(WORD_BITS);
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(WORD_BITS - 1);

  tx_state_e            state;
  logic [CNT_W-1:0]     cnt;
  logic [IDX_W-1:0]     bit_idx;
  logic [WORD_BITS-1:0] shreg;
  logic [CNT_W-1:0]     half_last, gap_last;
  logic                 half_end, gap_end;

  assign half_last = CNT_W'(phase_len(cfg_slow, HALF_FAST, HALF_SLOW) - 1);
  assign gap_last  = CNT_W'(phase_len(cfg_slow, GAP_FAST, GAP_SLOW) - 1);
  assign half_end  = (cnt >= half_last);
  assign gap_end   = (cnt >= gap_last);

  assign pop = tx_enable && have_word &&
               ((state == TX_IDLE) || (state == TX_GAP && gap_end));
  assign word_done = (state == TX_MARK) && half_end && (bit_idx == LAST_BIT);
  assign busy = (state != TX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= TX_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
    end else if (pop) begin
      state   <= TX_MARK;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= WORD_BITS'(frame_word(32'(head_word), cfg_par_en, cfg_par_even));
    end else begin
      unique case (state)
        TX_IDLE: cnt <= '0;
        TX_MARK: begin
          if (half_end) begin
            cnt   <= '0;
            state <= word_done ? TX_GAP : TX_SPACE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        TX_SPACE: begin
          if (half_end) begin
            cnt     <= '0;
            state   <= TX_MARK;
            bit_idx <= bit_idx + 1'b1;
            shreg   <= shreg >> 1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        TX_GAP: begin
          if (gap_end) begin
            cnt   <= '0;
            state <= TX_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  logic drive_one, drive_zero;
  assign drive_one  = (state == TX_MARK) && shreg[0];
  assign drive_zero = (state == TX_MARK) && !shreg[0];
  assign line_a = drive_one  && !test_null;
  assign line_b = drive_zero && !test_null;
endmodule

// File: rtl/a429_word_tx.sv
module a429_word_tx #(
  parameter int HALF_W    = 16,
  parameter int DEPTH     = 32,
  parameter int HALF_FAST = 5,
  parameter int HALF_SLOW = 40,
  parameter int GAP_FAST  = 40,
  parameter int GAP_SLOW  = 320
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_slow,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              wr_en,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              tx_enable,
  input  logic              test_null,
  output logic              line_a,
  output logic              line_b,
  output logic              tx_ready,
  output logic              fifo_full
);
  localparam int WORD_BITS = 2 * HALF_W;

  logic                    push_evt, pop_evt, word_done, ser_busy, q_empty;
  logic [WORD_BITS-1:0]    push_word, head_word;
  logic [$clog2(DEPTH):0]  fill_level;

  a429_half_loader #(.HALF_W(HALF_W)) u_loader (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .push(push_evt), .push_word(push_word)
  );

  a429_tx_fifo #(.WIDTH(WORD_BITS), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push_evt), .push_word(push_word),
    .pop(pop_evt), .head_word(head_word), .empty(q_empty),
    .full(fifo_full), .fill(fill_level)
  );

  a429_tx_serializer #(
    .WORD_BITS(WORD_BITS), .HALF_FAST(HALF_FAST), .HALF_SLOW(HALF_SLOW),
    .GAP_FAST(GAP_FAST), .GAP_SLOW(GAP_SLOW)
  ) u_ser (
    .clk(clk), .rst(rst), .cfg_slow(cfg_slow), .cfg_par_en(cfg_par_en),
    .cfg_par_even(cfg_par_even), .tx_enable(tx_enable), .test_null(test_null),
    .have_word(!q_empty), .head_word(head_word), .pop(pop_evt),
    .word_done(word_done), .busy(ser_busy), .line_a(line_a), .line_b(line_b)
  );

  assign tx_ready = q_empty && !ser_busy;
endmodule

// File: rtl/a429_word_tx_checker.sv
module a429_word_tx_checker #(
  parameter int DEPTH = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   line_a,
  input logic                   line_b,
  input logic                   test_null,
  input logic                   tx_ready,
  input logic                   fifo_full,
  input logic                   pop_evt,
  input logic                   push_evt,
  input logic [$clog2(DEPTH):0] fill_level
);
  assert_no_overdrive_R3: assert property (@(posedge clk) disable iff (rst)
    !(line_a && line_b));

  assert_test_forces_null_R6: assert property (@(posedge clk) disable iff (rst)
    test_null |-> (!line_a && !line_b));

  assert_pop_starts_bit_R7: assert property (@(posedge clk) disable iff (rst)
    pop_evt |=> (test_null || line_a || line_b));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    fill_level <= ($clog2(DEPTH)+1)'(DEPTH));

  assert_full_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (fifo_full && !pop_evt) |=> fifo_full);

  assert_push_grows_R9: assert property (@(posedge clk) disable iff (rst)
    (push_evt && !pop_evt && !fifo_full) |=> (fill_level == $past(fill_level) + 1'b1));

  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> (tx_ready && !fifo_full && !line_a && !line_b));
endmodule

bind a429_word_tx a429_word_tx_checker #(.DEPTH(DEPTH)) u_checker (
  .clk(clk), .rst(rst), .line_a(line_a), .line_b(line_b),
  .test_null(test_null), .tx_ready(tx_ready), .fifo_full(fifo_full),
  .pop_evt(pop_evt), .push_evt(push_evt), .fill_level(fill_level)
);

// File: tb/a429_word_tx_bench.sv
module a429_word_tx_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_slow = 1'b0, cfg_par_en = 1'b1, cfg_par_even = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic tx_enable = 1'b0, test_null = 1'b0;
  logic line_a, line_b, tx_ready, fifo_full;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [31:0] exp_q [0:39];
  int n_exp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  a429_word_tx u_a429_word_tx (
    .clk(clk), .rst(rst), .cfg_slow(cfg_slow), .cfg_par_en(cfg_par_en),
    .cfg_par_even(cfg_par_even), .wr_en(wr_en), .wr_data(wr_data),
    .tx_enable(tx_enable), .test_null(test_null), .line_a(line_a),
    .line_b(line_b), .tx_ready(tx_ready), .fifo_full(fifo_full)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Word expected on the line: count ones to build the parity bit.
  function automatic logic [31:0] expect_word(input logic [31:0] raw);
    int ones = 0;
    logic [31:0] w = raw;
    if (cfg_par_en) begin
      for (int i = 0; i < 31; i++) ones += int'(raw[i]);
      if (cfg_par_even) w[31] = (ones % 2 == 1);
      else              w[31] = (ones % 2 == 0);
    end
    return w;
  endfunction

  task automatic write_word(input logic [31:0] w);
    wr_en = 1'b1; wr_data = w[15:0];
    @(negedge clk); wr_data = w[31:16];
    @(negedge clk); wr_en = 1'b0;
    exp_q[n_exp] = expect_word(w);
    n_exp++;
  endtask

  task automatic do_reset();
    rst = 1'b1; tx_enable = 1'b0; wr_en = 1'b0; test_null = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0; n_exp = 0;
  endtask

  // Starts at a negedge; compares every clock of n words against the expected waveform.
  task automatic run_stream(input int n, input bit drop_en, input string tag);
    int h = cfg_slow ? 40 : 5;
    int g = cfg_slow ? 320 : 40;
    tx_enable = 1'b1;
    @(posedge clk);
    for (int w = 0; w < n; w++) begin
      int bad = 0;
      logic [1:0] fa = '0, fe = '0;
      for (int b = 0; b < 32; b++) begin
        logic lv = exp_q[w][b];
        for (int k = 0; k < h; k++) begin
          @(negedge clk);
          if (drop_en && w == 0 && b == 0 && k == 0) tx_enable = 1'b0;
          if ({line_a, line_b} != {lv, ~lv}) begin
            if (bad == 0) begin fa = {line_a, line_b}; fe = {lv, ~lv}; end
            bad++;
          end
        end
        for (int k = 0; k < ((b < 31) ? h : g); k++) begin
          @(negedge clk);
          if ({line_a, line_b} != 2'b00) begin
            if (bad == 0) begin fa = {line_a, line_b}; fe = 2'b00; end
            bad++;
          end
        end
      end
      chk(bad == 0, tag, $sformatf("word %0d waveform", w), 64'(fa), 64'(fe));
    end
  endtask

  task automatic stay_null(input int n, input string tag, input string what);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (line_a || line_b) bad++;
    end
    chk(bad == 0, tag, what, 64'(bad), 64'd0);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(tx_ready == 1'b1, "R11", "ready after reset", 64'(tx_ready), 64'd1);
    chk(fifo_full == 1'b0, "R11", "full after reset", 64'(fifo_full), 64'd0);
    chk({line_a, line_b} == 2'b00, "R11", "lines after reset", 64'({line_a, line_b}), 64'd0);
  endtask

  task automatic t_fast_odd();
    do_reset();
    cfg_slow = 0; cfg_par_en = 1; cfg_par_even = 0;
    write_word(32'h0000_0001);
    chk(tx_ready == 1'b0, "R7", "ready with queued word", 64'(tx_ready), 64'd0);
    run_stream(1, 0, "R1 R3 R4 odd");
    @(negedge clk);
    chk(tx_ready == 1'b1, "R7", "ready after last gap", 64'(tx_ready), 64'd1);
  endtask

  task automatic t_fast_even_pair();
    do_reset();
    cfg_slow = 0; cfg_par_en = 1; cfg_par_even = 1;
    write_word(32'hA5C3_0F71);
    write_word(32'h7FFF_FFFF);
    run_stream(2, 0, "R1 R4 R7 even back-to-back");
    @(negedge clk);
    chk(tx_ready == 1'b1, "R7", "ready after two words", 64'(tx_ready), 64'd1);
  endtask

  task automatic t_slow_bypass();
    do_reset();
    cfg_slow = 1; cfg_par_en = 0; cfg_par_even = 0;
    write_word(32'h8000_0003);
    write_word(32'h1234_5678);
    run_stream(2, 0, "R2 R5 R3 slow raw");
    @(negedge clk);
    chk(tx_ready == 1'b1, "R2", "ready after slow words", 64'(tx_ready), 64'd1);
    cfg_slow = 0; cfg_par_en = 1;
  endtask

  task automatic t_test_null();
    do_reset();
    write_word(32'hFFFF_FFFF);
    tx_enable = 1'b1; test_null = 1'b1;
    stay_null(120, "R6", "null while test active");
    test_null = 1'b0;
    for (int k = 0; k < 2000 && !tx_ready; k++) @(negedge clk);
    chk(tx_ready == 1'b1, "R6", "word finishes after test released", 64'(tx_ready), 64'd1);
    tx_enable = 1'b0;
  endtask

  task automatic t_half_only();
    do_reset();
    wr_en = 1'b1; wr_data = 16'hBEEF;
    @(negedge clk); wr_en = 1'b0;
    tx_enable = 1'b1;
    stay_null(60, "R9", "lone lower half not sent");
    chk(tx_ready == 1'b1, "R9", "ready with lone lower half", 64'(tx_ready), 64'd1);
    tx_enable = 1'b0;
    // Next write completes the pending word as its upper half.
    wr_en = 1'b1; wr_data = 16'h0102;
    @(negedge clk); wr_en = 1'b0;
    exp_q[0] = expect_word(32'h0102_BEEF); n_exp = 1;
    run_stream(1, 0, "R9 halves joined");
    tx_enable = 1'b0;
  endtask

  task automatic t_fill_full();
    do_reset();
    cfg_par_en = 0;
    for (int i = 0; i < 32; i++) write_word(32'h0100_0000 * i + 32'h0000_5A00 + i);
    chk(fifo_full == 1'b1, "R8", "full after 32 words", 64'(fifo_full), 64'd1);
    write_word(32'hDEAD_BEEF);
    chk(fifo_full == 1'b1, "R8", "still full after extra word", 64'(fifo_full), 64'd1);
    run_stream(32, 0, "R8 drain 32");
    @(negedge clk);
    chk(tx_ready == 1'b1, "R8", "ready after 32 words, extra dropped", 64'(tx_ready), 64'd1);
    stay_null(80, "R8", "33rd word never sent");
    tx_enable = 1'b0; cfg_par_en = 1;
  endtask

  task automatic t_enable_drop();
    do_reset();
    write_word(32'h00FF_00FF);
    write_word(32'h1111_1111);
    run_stream(1, 1, "R10 word completes");
    @(negedge clk);
    chk(tx_ready == 1'b0, "R10", "second word still queued", 64'(tx_ready), 64'd0);
    stay_null(200, "R10", "no new word while disabled");
  endtask

  task automatic t_reset_midword();
    do_reset();
    write_word(32'hFFFF_FFFF);
    write_word(32'hFFFF_FFFF);
    tx_enable = 1'b1;
    for (int k = 0; k < 23; k++) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk({line_a, line_b} == 2'b00, "R11", "lines null after mid-word reset", 64'({line_a, line_b}), 64'd0);
    chk(tx_ready == 1'b1, "R11", "queue emptied by reset", 64'(tx_ready), 64'd1);
    rst = 1'b0;
    stay_null(100, "R11", "no stale word after reset");
    tx_enable = 1'b0;
  endtask

  initial begin
    t_reset_state();
    t_fast_odd();
    t_fast_even_pair();
    t_slow_bypass();
    t_test_null();
    t_half_only();
    t_fill_full();
    t_enable_drop();
    t_reset_midword();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule